// File: doc/BRIEF.md
# Fixed-Range XOR Checksum Verifier

This block checks a 256-byte memory image that has already been loaded into a byte buffer. A start strobe begins a single sweep over the buffer. The block reads one byte per clock through the buffer's read port and keeps a running bytewise XOR. The image is split into three back-to-back regions. Each region ends with a byte that holds the expected XOR of the data bytes before it. When the sweep reaches a region's checksum byte, the block compares that byte with the running value, then restarts the running value at zero for the next region.

Each region has its own error flag. A mismatch sets the flag, and the flag stays high until software reads the status word with the read strobe. The status word also carries the live level of an external enable pin. Loading the buffer and writing checksums back are handled elsewhere.

Top module: `xor_sum_checker`

## Requirements
- R1: While reset is held and directly after it, `status` is zero except bit 15, and `busy`, `done` and `buf_rd_en` are low.
- R2: A start strobe while idle makes the block assert `buf_rd_en` for exactly 256 consecutive cycles, presenting buffer addresses 0x00 to 0xFF in rising order. The read data is taken one cycle after its address.
- R3: Region A holds data at addresses 0x00..0x75 and its checksum at 0x76. A mismatch sets status bit 0, and a match leaves it clear.
- R4: Region B holds data at 0x77..0xA5 and its checksum at 0xA6. A mismatch sets status bit 2.
- R5: Region C holds data at 0xA7..0xFE and its checksum at 0xFF. A mismatch sets status bit 3.
- R6: The checksum is the bytewise XOR of the region's data bytes, not their arithmetic sum. A checksum byte equal to the sum but not the XOR is a mismatch.
- R7: `done` pulses high for one cycle, two cycles after the read of address 0xFF. In that same cycle the flags for that run are visible and `busy` drops.
- R8: An error flag stays high across idle cycles and later runs until a cycle with `stat_rd` high. During that read cycle `status` still shows the flag, and from the next cycle on the flag reads zero.
- R9: If a mismatch is detected in the same cycle as a status read, the flag is set after that cycle.
- R10: Status bit 15 follows `en_pin` combinationally. Bits 14:4 and bit 1 always read zero.
- R11: A start strobe while `busy` is high is ignored. The running sweep still makes exactly 256 reads and one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (ignored while busy) |
| stat_rd | input | 1 | Status read strobe; clears error flags after this cycle |
| en_pin | input | 1 | External enable level reported in status bit 15 |
| buf_rd_en | output | 1 | Buffer read request |
| buf_addr | output | 8 | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after the request |
| status | output | 16 | Status word: bit 15 pin level, bits 3/2/0 region C/B/A error |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when all three comparisons are complete |

## Verification
The bench uses the default parameters: an 8-bit address, 8-bit data, and checksum bytes at 0x76, 0xA6 and 0xFF. With these values the last checksum sits at the top of the address space. This lets the bench check that the address counter stops at 0xFF instead of wrapping, and that the region C comparison lines up with the final read. Because the regions are contiguous, a single sweep covers every boundary between regions. The bench can therefore plant a mismatch in any one region and see that only that region's flag is set. It can also time a status read onto the exact cycle of the region C comparison, which exercises R9.

// File: rtl/xor_sum_checker.sv
module xor_sum_checker #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] FIRST = 'h00,
  parameter logic [AW-1:0] CS_A  = 'h76,
  parameter logic [AW-1:0] CS_B  = 'hA6,
  parameter logic [AW-1:0] CS_C  = 'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stat_rd,
  input  logic          en_pin,
  output logic          buf_rd_en,
  output logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_rdata,
  output logic [15:0]   status,
  output logic          busy,
  output logic          done
);

  logic          run, issue, vld, done_q;
  logic [AW-1:0] addr, addr_d;
  logic [DW-1:0] acc;
  logic [2:0]    flags, miss;
  logic          at_a, at_b, at_c, at_cs;

  assign at_a  = vld && (addr_d == CS_A);
  assign at_b  = vld && (addr_d == CS_B);
  assign at_c  = vld && (addr_d == CS_C);
  assign at_cs = at_a || at_b || at_c;

  assign miss[0] = at_a && (acc != buf_rdata);
  assign miss[1] = at_b && (acc != buf_rdata);
  assign miss[2] = at_c && (acc != buf_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      issue  <= 1'b0;
      vld    <= 1'b0;
      done_q <= 1'b0;
      addr   <= FIRST;
      addr_d <= FIRST;
      acc    <= '0;
    end else begin
      vld    <= issue;
      addr_d <= addr;
      done_q <= at_c;
      if (vld)
        acc <= at_cs ? '0 : (acc ^ buf_rdata);
      if (at_c)
        run <= 1'b0;
      if (start && !run) begin
        run   <= 1'b1;
        issue <= 1'b1;
        addr  <= FIRST;
        acc   <= '0;
      end else if (issue) begin
        if (addr == CS_C) issue <= 1'b0;
        else              addr  <= addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{3{stat_rd}}) | miss;
  end

  assign buf_rd_en = issue;
  assign buf_addr  = addr;
  assign busy      = run;
  assign done      = done_q;
  assign status    = {en_pin, 11'b0, flags[2], flags[1], 1'b0, flags[0]};

endmodule

module xor_sum_checker_sva #(
  parameter int AW = 8,
  parameter logic [AW-1:0] LAST = 'hFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stat_rd,
  input logic          en_pin,
  input logic          buf_rd_en,
  input logic [AW-1:0] buf_addr,
  input logic [15:0]   status,
  input logic          busy,
  input logic          done
);

  assert_rd_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> busy);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en && buf_addr != LAST) |=> (buf_rd_en && buf_addr == $past(buf_addr) + 1'b1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !stat_rd) |=> status[0]);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !busy) |=> (status[3:0] == 4'b0));

  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[14:4] == 11'b0) && !status[1] && (status[15] == en_pin));

  assert_start_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done));

endmodule

bind xor_sum_checker xor_sum_checker_sva #(.AW(AW), .LAST(CS_C)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .stat_rd(stat_rd), .en_pin(en_pin),
  .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .status(status), .busy(busy), .done(done));

// File: tb/tb_xor_sum_checker.sv
module tb_xor_sum_checker;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stat_rd = 1'b0, en_pin = 1'b0;
  logic buf_rd_en, busy, done;
  logic [7:0] buf_addr;
  logic [7:0] buf_rdata = 8'h00;
  logic [15:0] status;
  logic [7:0] mem [256];

  int nchk = 0, nerr = 0, cyc = 0;
  int reads = 0, dones = 0, addr_bad = 0, exp_addr = 0;

  always #4 clk = ~clk;

  xor_sum_checker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stat_rd(stat_rd), .en_pin(en_pin),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .status(status), .busy(busy), .done(done));

  always @(posedge clk) if (buf_rd_en) buf_rdata <= mem[buf_addr];

  always @(negedge clk) begin
    if (buf_rd_en) begin
      if (buf_addr !== exp_addr[7:0]) addr_bad++;
      exp_addr++;
      reads++;
    end
    if (done) dones++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_image(input int seed);
    logic [7:0] a, b, c;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + seed);
    a = 0; b = 0; c = 0;
    for (int i = 'h00; i <= 'h75; i++) a ^= mem[i];
    for (int i = 'h77; i <= 'hA5; i++) b ^= mem[i];
    for (int i = 'hA7; i <= 'hFE; i++) c ^= mem[i];
    mem['h76] = a; mem['hA6] = b; mem['hFF] = c;
  endtask

  task automatic clear_counts();
    reads = 0; dones = 0; addr_bad = 0; exp_addr = 0;
  endtask

  task automatic do_read();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic run_sweep();
    clear_counts();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 600 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status in reset", status, 16'h0000);
    check("R1 busy/done/rd in reset", {busy, done, buf_rd_en}, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 16'h0000);
    check("R1 busy/done/rd after reset", {busy, done, buf_rd_en}, 3'b000);
  endtask

  task automatic t_clean();
    fill_image(11);
    run_sweep();
    check("R7 done seen", done, 1'b1);
    check("R7 busy low at done", busy, 1'b0);
    check("R3 R4 R5 no flags on good image", status[3:0], 4'h0);
    @(negedge clk);
    check("R7 done single cycle", done, 1'b0);
    check("R2 read count", reads, 256);
    check("R2 address order", addr_bad, 0);
    check("R7 done count", dones, 1);
  endtask

  task automatic t_region(input int cs, input logic [3:0] exp, input string req);
    fill_image(cs);
    mem[cs] ^= 8'h5A;
    run_sweep();
    check(req, status[3:0], exp);
    do_read();
  endtask

  task automatic t_xor_not_add();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem['h10] = 8'h01; mem['h20] = 8'h01;
    mem['h80] = 8'h03; mem['h90] = 8'h05; mem['hA6] = 8'h06;
    mem['hB0] = 8'h01; mem['hC0] = 8'h01; mem['hFF] = 8'h02;
    run_sweep();
    check("R6 xor used, sum rejected", status[3:0], 4'b1000);
    do_read();
  endtask

  task automatic t_clear_on_read();
    fill_image(3);
    mem['h76] ^= 8'h01;
    run_sweep();
    repeat (5) @(negedge clk);
    check("R8 flag holds while idle", status[0], 1'b1);
    fill_image(3);
    run_sweep();
    check("R8 flag holds across clean run", status[0], 1'b1);
    @(negedge clk) stat_rd = 1'b1;
    #1 check("R8 flag visible during read", status[0], 1'b1);
    @(negedge clk) stat_rd = 1'b0;
    check("R8 flag cleared after read", status[3:0], 4'h0);
  endtask

  task automatic t_sticky();
    fill_image(9);
    mem['hFF] ^= 8'h80;
    clear_counts();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (256) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    check("R7 done timing", done, 1'b1);
    check("R9 flag set despite read", status[3], 1'b1);
    do_read();
    check("R9 flag clears on later read", status[3], 1'b0);
  endtask

  task automatic t_pin();
    en_pin = 1'b1;
    #1 check("R10 pin high", status, 16'h8000);
    en_pin = 1'b0;
    #1 check("R10 pin low", status, 16'h0000);
  endtask

  task automatic t_restart_ignored();
    fill_image(21);
    mem['hA6] ^= 8'h11;
    clear_counts();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 600 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 reads with second start", reads, 256);
    check("R11 one done", dones, 1);
    check("R11 order kept", addr_bad, 0);
    check("R11 result kept", status[3:0], 4'b0100);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_clean();
    t_region('h76, 4'b0001, "R3 region A mismatch");
    t_region('hA6, 4'b0100, "R4 region B mismatch");
    t_region('hFF, 4'b1000, "R5 region C mismatch");
    t_xor_not_add();
    t_clear_on_read();
    t_sticky();
    t_pin();
    t_restart_ignored();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

endmodule